// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two 12-bit unsigned operands over several clock cycles and delivers a 24-bit product. A two-state controller sits idle and raises a combinational ready flag while it can take new work. When the producer raises go_i during that idle time, both operands are captured and the controller moves to its loop state. The loop state runs twelve steps. In each step the multiplicand is added to the running partial product when the current multiplier bit is set, and then the pair is shifted right by one bit.

When the last step is taken, the controller returns to idle and updates the product register. A done flag is raised for a single cycle at that point. The product then stays unchanged until the next operation finishes, so a consumer may read it at any time after done.

Top module: `seq_mult`

## Requirements
- R1: product_o equals a_i * b_i as unsigned values, using the operands captured at the accepting edge, for every 12-bit operand pair including 0 and 4095.
- R2: When rst_ni is low (asserted asynchronously, even in the middle of an operation), the controller goes idle: ready_o=1, done_o=0, product_o=0.
- R3: ready_o is high exactly while the controller is idle. It is low from the edge that accepts go_i until the edge that raises done_o.
- R4: A rising clock edge with go_i=1 and ready_o=1 captures a_i and b_i. Changes on a_i and b_i after that edge do not affect the result.
- R5: done_o rises on the 12th rising edge after the accepting edge and is high for exactly one cycle.
- R6: go_i is ignored while ready_o is low. Holding it high during an operation neither restarts the operation nor changes when done_o rises.
- R7: product_o changes only on the edge that raises done_o and holds its value between completions.
- R8: ready_o is high in the done_o cycle, so go_i held high then starts a new operation at the next edge (back-to-back operation).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start request, sampled while idle |
| a_i | input | 12 | Multiplicand operand |
| b_i | input | 12 | Multiplier operand |
| ready_o | output | 1 | High while idle; new operands accepted |
| done_o | output | 1 | One-cycle pulse marking a new product |
| product_o | output | 24 | Unsigned product, held between completions |

## Verification
On every cycle, the assertions check these timing rules:
- done_o implies ready_o.
- done_o never lasts two cycles.
- The final step is always followed by done.
- The loop counter only advances while busy, whatever go_i does.
- product_o stays stable outside completions.

The arithmetic itself (R1) can only be shown by the bench's scenarios. The same holds for these behaviours:
- the exact twelve-edge latency;
- the fact that operand changes after capture have no effect;
- back-to-back starts;
- a reset in mid-operation.

The bench compares each of these against products and edge counts that it computes on its own.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_LOOP = 1'b1} mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
  parameter int unsigned STEPS = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic ready_o,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic done_o
);
  import mul_pkg::*;
  localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(STEPS - 1);

  mul_state_e    state_q;
  logic [CW-1:0] cnt_q;

  assign ready_o = (state_q == ST_IDLE);
  assign load_o  = ready_o && go_i;
  assign step_o  = (state_q == ST_LOOP);
  assign last_o  = step_o && (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= last_o;
      if (load_o) begin
        state_q <= ST_LOOP;
        cnt_q   <= '0;
      end else if (last_o) begin
        state_q <= ST_IDLE;
      end else if (step_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5: the last step always produces done on the next cycle, and done lasts one cycle
  a_r5_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> done_o);
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R3 / R8: done is only ever seen while idle
  a_r3_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
  // R6: a busy machine keeps counting regardless of go
  a_r6_busy_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !last_o) |=> (step_o && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int unsigned W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic           last_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  logic [W-1:0] mcand_q, acc_q, mplr_q;
  logic [W:0]   sum;
  logic [W-1:0] acc_nxt, mplr_nxt;

  // conditional add, then shift {carry, sum, multiplier} right by one
  always_comb begin
    sum      = {1'b0, acc_q} + (mplr_q[0] ? {1'b0, mcand_q} : '0);
    acc_nxt  = sum[W:1];
    mplr_nxt = {sum[0], mplr_q[W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      acc_q   <= '0;
      mplr_q  <= '0;
      prod_o  <= '0;
    end else begin
      if (load_i) begin
        mcand_q <= a_i;
        mplr_q  <= b_i;
        acc_q   <= '0;
      end else if (step_i) begin
        acc_q  <= acc_nxt;
        mplr_q <= mplr_nxt;
      end
      if (last_i) prod_o <= {acc_nxt, mplr_nxt};
    end
  end

  // R7: the result register moves only on the final step
  a_r7_prod_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> $stable(prod_o));
endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int unsigned W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           go_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           ready_o,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);
  logic load, step, last;

  mul_ctrl #(.STEPS(W)) u_ctrl (
    .clk_i, .rst_ni, .go_i,
    .ready_o, .load_o(load), .step_o(step), .last_o(last), .done_o
  );

  mul_datapath #(.W(W)) u_dp (
    .clk_i, .rst_ni,
    .load_i(load), .step_i(step), .last_i(last),
    .a_i, .b_i, .prod_o(product_o)
  );

  // R3: ready drops right after an accepted request
  a_r3_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && go_i) |=> !ready_o);
endmodule

// File: tb/sim_seq_mult.sv
module sim_seq_mult;
  localparam int W = 12;
  localparam int NV = 10;
  localparam logic [2*W-1:0] VEC [NV] = '{
    {12'd0,    12'd0},    {12'd1,    12'd1},    {12'd4095, 12'd4095},
    {12'd4095, 12'd1},    {12'd0,    12'd4095}, {12'd123,  12'd456},
    {12'd2048, 12'd2048}, {12'd2730, 12'd1365}, {12'd17,   12'd3001},
    {12'd3999, 12'd77}
  };

  logic clk = 1'b0, rst_ni = 1'b0, go_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic ready_o, done_o;
  logic [2*W-1:0] product_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  seq_mult #(.W(W)) u0 (.clk_i(clk), .rst_ni, .go_i, .a_i, .b_i,
                        .ready_o, .done_o, .product_o);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // drive operands with go at a negedge; return after done is seen at a negedge
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic noise, input logic chain);
    int n;
    logic [2*W-1:0] exp;
    exp = 24'(a) * 24'(b);
    a_i = a; b_i = b; go_i = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R3 ready low after accept", ready_o, 0);
    go_i = noise; a_i = ~a; b_i = ~b;   // R4, R6 disturbances
    n = 1;
    while (!done_o && n < 40) begin
      @(negedge clk); n++;
      if (!done_o && ready_o) check("R3 ready low while busy", ready_o, 0);
    end
    if (!chain) go_i = 1'b0;
    check("R5 latency", n, 13);
    check("R1 product", product_o, exp);
    check("R8 ready in done cycle", ready_o, 1);
  endtask

  initial begin
    #1_600_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [2*W-1:0] held;
    #2;
    check("R2 reset ready", ready_o, 1);
    check("R2 reset done", done_o, 0);
    check("R2 reset product", product_o, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R3 ready idle", ready_o, 1);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][2*W-1:W], VEC[i][W-1:0], i[0], 1'b0);
      held = product_o;
      @(negedge clk);
      check("R5 done one cycle", done_o, 0);
      check("R7 product held", product_o, held);
    end

    // R7: hold over idle time
    repeat (20) @(negedge clk);
    check("R7 product held idle", product_o, held);

    // R8: back-to-back, go held into the done cycle
    run_op(12'd300, 12'd11, 1'b1, 1'b1);
    run_op(12'd4095, 12'd2, 1'b0, 1'b0);

    // R2: reset mid-operation
    a_i = 12'd9; b_i = 12'd9; go_i = 1'b1;
    @(posedge clk); @(negedge clk); go_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b0; #1;
    check("R2 mid reset ready", ready_o, 1);
    check("R2 mid reset done", done_o, 0);
    check("R2 mid reset product", product_o, 0);
    @(negedge clk); rst_ni = 1'b1; @(negedge clk);
    repeat (15) @(negedge clk);
    check("R2 no done after reset", done_o, 0);
    run_op(12'd1000, 12'd1000, 1'b1, 1'b0);
    summary();
  end
endmodule